// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block holds the message-signalled interrupt state of one function: a table of message vectors (address, data and a per-vector mask), a bit array of pending interrupts, and the two function-level control bits, enable and mask-all. Software reaches the table and the pending array through one 4 KiB register page on a simple 32-bit register bus. The control bits are loaded through a separate write strobe from the function's capability logic.

Device logic raises an interrupt by presenting a vector number with a valid/ready handshake. The block then does one of three things. It drops the request if the vector is out of range or not declared in use. It records the request as pending if the vector is masked. Otherwise it emits the vector's message as a 64-bit address and 32-bit data on a valid/ready write port. When a vector-control write or a control-bit write can unmask vectors, a sequential scan walks the table in ascending order. The scan clears each pending bit whose vector is now unmasked and sends that vector's message, one message per accepted transfer. Interrupt requests are held off while the scan runs.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, enable and mask-all are 0, every table word reads 0 except the vector-control word of each configured vector, which reads 1. The pending word reads 0, no message is offered, and `tbl_size` reports NUM_VEC-1.
- R2: Register page layout. Address bits [11:4] select the entry while bit 11 is 0. Word 0 is the low address half, word 1 the high address half, word 2 the data, and word 3 the vector control, whose bit 0 is the mask; its other bits read 0. Address bits [1:0] are ignored. Reads are combinational.
- R3: The pending word is at offset 0x800, with bit v holding vector v. Writes to it, and to any entry index at or above NUM_VEC, change nothing. Reads of unmapped offsets return 0.
- R4: A vector is masked when its mask bit is 1, or enable is 0, or mask-all is 1. A request to a masked, in-use vector sets its pending bit and sends nothing.
- R5: A request accepted for an unmasked, in-use vector offers that entry's address and data on the message port in the following cycle.
- R6: A vector-control write that clears the mask of a pending vector, while the function is unmasked, clears the pending bit and sends that vector's message.
- R7: A control write that leaves the function unmasked replays every pending vector that is no longer masked, in ascending vector order.
- R8: A request naming a vector at or above NUM_VEC, or a vector whose use count is 0, is dropped: no message is sent and no pending bit is set.
- R9: Use counts go up on `use_inc` and down on `use_dec` for the vector on `use_idx`. A vector stays usable while its count is above 0. When the count drops to 0, its pending bit is cleared.
- R10: A message offered on the port keeps its address and data until `msg_ready` takes it. `irq_ready` is low while a message is waiting or a scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 12 | Byte address within the page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| ctl_we | input | 1 | Load the control bits |
| ctl_enable | input | 1 | New enable value |
| ctl_fmask | input | 1 | New mask-all value |
| cfg_enable | output | 1 | Current enable bit |
| cfg_fmask | output | 1 | Current mask-all bit |
| tbl_size | output | 5 | Configured vector count minus one |
| use_inc | input | 1 | Increment a vector's use count |
| use_dec | input | 1 | Decrement a vector's use count |
| use_idx | input | 5 | Vector for use-count update |
| irq_valid | input | 1 | Interrupt request valid |
| irq_vec | input | 5 | Requested vector |
| irq_ready | output | 1 | Request accepted this cycle |
| msg_valid | output | 1 | Message offered |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_ready | input | 1 | Message taken this cycle |

## Verification
Requests are swept over every configured vector, plus one unused vector and one out-of-range number. This separates delivery, latching as pending and silent dropping. Unmasking is exercised three ways: by clearing a per-vector mask, by clearing mask-all, and by setting enable again. The three paths must all replay, while a per-vector unmask under a function mask must not. One replay runs with the write port stalled, to show that the message holds and that the scan keeps its order. Use counts are taken up twice and back down to show that only the fall to zero clears pending state.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MAX_VEC   = 32;
  localparam int VEC_IDX_W = 5;
  localparam int PAGE_AW   = 12;

  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} scan_st_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/msix_entry_store.sv
module msix_entry_store
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [VEC_IDX_W-1:0] wr_idx,
  input  logic [1:0]           wr_word,
  input  logic [31:0]          wr_data,
  input  logic [VEC_IDX_W-1:0] rd_idx,
  input  logic [1:0]           rd_word,
  output logic [31:0]          rd_data,
  input  logic [VEC_IDX_W-1:0] sel_idx,
  output msg_t                 sel_msg,
  output logic [NUM_VEC-1:0]   vmask
);
  logic [NUM_VEC-1:0][31:0] lo_all, hi_all, dat_all;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    logic [31:0] lo_q, hi_q, dat_q;
    logic        msk_q;
    logic        hit;
    assign hit = wr_en && (wr_idx == VEC_IDX_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else if (hit) begin
        case (wr_word)
          2'd0:    lo_q  <= wr_data;
          2'd1:    hi_q  <= wr_data;
          2'd2:    dat_q <= wr_data;
          default: msk_q <= wr_data[0];
        endcase
      end
    end

    assign lo_all[v]  = lo_q;
    assign hi_all[v]  = hi_q;
    assign dat_all[v] = dat_q;
    assign vmask[v]   = msk_q;
  end

  always_comb begin
    rd_data = '0;
    sel_msg = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (rd_idx == VEC_IDX_W'(v)) begin
        case (rd_word)
          2'd0:    rd_data = lo_all[v];
          2'd1:    rd_data = hi_all[v];
          2'd2:    rd_data = dat_all[v];
          default: rd_data = {31'b0, vmask[v]};
        endcase
      end
      if (sel_idx == VEC_IDX_W'(v)) begin
        sel_msg.addr = {hi_all[v], lo_all[v]};
        sel_msg.data = dat_all[v];
      end
    end
  end
endmodule

// File: rtl/msix_use_cnt.sv
module msix_use_cnt
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic                 dec,
  input  logic [VEC_IDX_W-1:0] idx,
  output logic [NUM_VEC-1:0]   used,
  output logic [NUM_VEC-1:0]   fall_zero
);
  localparam logic [USE_W-1:0] CNT_MAX = '1;
  localparam logic [USE_W-1:0] CNT_ONE = USE_W'(1);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
    logic [USE_W-1:0] cnt_q, cnt_d;
    logic             hit, up, dn;

    assign hit = (idx == VEC_IDX_W'(v));
    assign up  = hit && inc && !dec && (cnt_q != CNT_MAX);
    assign dn  = hit && dec && !inc && (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (up)      cnt_d = cnt_q + CNT_ONE;
      else if (dn) cnt_d = cnt_q - CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (up || dn) cnt_q <= cnt_d;
    end

    assign used[v]      = (cnt_q != '0);
    assign fall_zero[v] = dn && (cnt_q == CNT_ONE);
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [PAGE_AW-1:0]   reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 ctl_we,
  input  logic                 ctl_enable,
  input  logic                 ctl_fmask,
  output logic                 cfg_enable,
  output logic                 cfg_fmask,
  output logic [VEC_IDX_W-1:0] tbl_size,
  input  logic                 use_inc,
  input  logic                 use_dec,
  input  logic [VEC_IDX_W-1:0] use_idx,
  input  logic                 irq_valid,
  input  logic [VEC_IDX_W-1:0] irq_vec,
  output logic                 irq_ready,
  output logic                 msg_valid,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data,
  input  logic                 msg_ready
);
  localparam int ENT_SH = 4;
  localparam int IDXF_W = PAGE_AW - 1 - ENT_SH;
  localparam logic [IDXF_W-1:0]    ENT_LIM  = IDXF_W'(NUM_VEC);
  localparam logic [VEC_IDX_W:0]   VEC_LIM  = (VEC_IDX_W+1)'(NUM_VEC);
  localparam logic [VEC_IDX_W-1:0] VEC_LAST = VEC_IDX_W'(NUM_VEC - 1);

  // ---------------- register page decode ----------------
  logic [IDXF_W-1:0]    ent_f;
  logic [VEC_IDX_W-1:0] ent_idx;
  logic [1:0]           ent_word;
  logic                 in_tbl, pend_rd, tbl_wr, addr_unused;
  logic [31:0]          st_rd;

  assign ent_f       = reg_addr[PAGE_AW-2:ENT_SH];
  assign ent_idx     = reg_addr[ENT_SH+VEC_IDX_W-1:ENT_SH];
  assign ent_word    = reg_addr[3:2];
  assign addr_unused = ^reg_addr[1:0];
  assign in_tbl      = !reg_addr[PAGE_AW-1] && (ent_f < ENT_LIM);
  assign pend_rd     = reg_addr[PAGE_AW-1] && (reg_addr[PAGE_AW-2:2] == '0);
  assign tbl_wr      = reg_req && reg_we && in_tbl;

  // ---------------- state ----------------
  logic                 en_q, fm_q;
  logic [NUM_VEC-1:0]   pend_q, pend_d;
  scan_st_e             st_q, st_d;
  logic [VEC_IDX_W-1:0] ptr_q, ptr_d;
  logic                 msg_vq, msg_vd;
  msg_t                 msg_q, sel_msg;

  logic [NUM_VEC-1:0]   vmask, masked_v, used_v, fall_v, irq_oh, ptr_oh;
  logic [VEC_IDX_W-1:0] sel_idx;
  logic func_m, irq_fire, irq_in, irq_send, cand, slot_free;
  logic scan_send, scan_step, unmask_ev, load;

  msix_entry_store #(.NUM_VEC(NUM_VEC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(ent_idx), .wr_word(ent_word), .wr_data(reg_wdata),
    .rd_idx(ent_idx), .rd_word(ent_word), .rd_data(st_rd),
    .sel_idx(sel_idx), .sel_msg(sel_msg), .vmask(vmask)
  );

  msix_use_cnt #(.NUM_VEC(NUM_VEC), .USE_W(USE_W)) u_use (
    .clk(clk), .rst_n(rst_n), .inc(use_inc), .dec(use_dec), .idx(use_idx),
    .used(used_v), .fall_zero(fall_v)
  );

  assign func_m   = !en_q || fm_q;
  assign masked_v = vmask | {NUM_VEC{func_m}};

  // ---------------- request path ----------------
  assign irq_ready = (st_q == ST_IDLE) && !msg_vq;
  assign irq_fire  = irq_valid && irq_ready;
  assign irq_in    = ({1'b0, irq_vec} < VEC_LIM);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_oh
    assign irq_oh[v] = irq_fire && irq_in && (irq_vec == VEC_IDX_W'(v));
    assign ptr_oh[v] = (ptr_q == VEC_IDX_W'(v));
  end

  assign irq_send = |(irq_oh & used_v & ~masked_v);

  // ---------------- replay scan ----------------
  assign unmask_ev = (tbl_wr && (ent_word == 2'd3) && !reg_wdata[0]) ||
                     (ctl_we && ctl_enable && !ctl_fmask);
  assign slot_free = !msg_vq || msg_ready;
  assign cand      = (st_q == ST_SCAN) && |(ptr_oh & pend_q & ~masked_v & used_v);
  assign scan_send = cand && slot_free;
  assign scan_step = (st_q == ST_SCAN) && (!cand || slot_free);

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (unmask_ev) begin
      st_d  = ST_SCAN;
      ptr_d = '0;
    end else if (scan_step) begin
      if (ptr_q == VEC_LAST) st_d  = ST_IDLE;
      else                   ptr_d = ptr_q + VEC_IDX_W'(1);
    end
  end

  // ---------------- pending and message next state ----------------
  assign sel_idx = (st_q == ST_SCAN) ? ptr_q : irq_vec;
  assign load    = irq_send || scan_send;

  always_comb begin
    pend_d = (pend_q | (irq_oh & used_v & masked_v)) & ~fall_v;
    if (scan_send) pend_d = pend_d & ~ptr_oh;
    msg_vd = load || (msg_vq && !msg_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fm_q   <= 1'b0;
      pend_q <= '0;
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      msg_vq <= 1'b0;
      msg_q  <= '0;
    end else begin
      if (ctl_we) begin
        en_q <= ctl_enable;
        fm_q <= ctl_fmask;
      end
      pend_q <= pend_d;
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      msg_vq <= msg_vd;
      if (load) msg_q <= sel_msg;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    reg_rdata = '0;
    if (in_tbl)       reg_rdata = st_rd;
    else if (pend_rd) reg_rdata = 32'(pend_q);
  end

  assign cfg_enable = en_q;
  assign cfg_fmask  = fm_q;
  assign tbl_size   = VEC_LAST;
  assign msg_valid  = msg_vq;
  assign msg_addr   = msg_q.addr;
  assign msg_data   = msg_q.data;
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_valid,
  input logic                 irq_ready,
  input logic [VEC_IDX_W-1:0] irq_vec,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [63:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NUM_VEC-1:0]   pend,
  input logic [NUM_VEC-1:0]   used,
  input logic [NUM_VEC-1:0]   masked
);
  localparam logic [VEC_IDX_W:0] LIM = (VEC_IDX_W+1)'(NUM_VEC);

  logic               fire, in_rng;
  logic [NUM_VEC-1:0] irq_sel;

  assign fire   = irq_valid && irq_ready;
  assign in_rng = ({1'b0, irq_vec} < LIM);

  always_comb begin
    irq_sel = '0;
    for (int v = 0; v < NUM_VEC; v++)
      if (in_rng && irq_vec == VEC_IDX_W'(v)) irq_sel[v] = 1'b1;
  end

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R10
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !irq_ready);

  // R8
  oor_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_rng |=> !msg_valid);

  // R9
  pend_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~used) == '0);

  // R5
  direct_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && |(irq_sel & used & ~masked) |=> msg_valid);
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NUM_VEC(NUM_VEC)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vec(irq_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .pend(pend_q), .used(used_v),
  .masked(masked_v)
);

// File: tb/test_msix_vec_ctrl.sv
module test_msix_vec_ctrl;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ctl_we = 1'b0, ctl_enable = 1'b0, ctl_fmask = 1'b0;
  logic        cfg_enable, cfg_fmask;
  logic [4:0]  tbl_size;
  logic        use_inc = 1'b0, use_dec = 1'b0;
  logic [4:0]  use_idx = '0;
  logic        irq_valid = 1'b0, irq_ready;
  logic [4:0]  irq_vec = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_run = 0, n_fail = 0, got_n = 0;
  logic [63:0] got_a [64];
  logic [31:0] got_d [64];

  always #10 clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(NV), .USE_W(4)) i_msix_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_fmask(ctl_fmask),
    .cfg_enable(cfg_enable), .cfg_fmask(cfg_fmask), .tbl_size(tbl_size),
    .use_inc(use_inc), .use_dec(use_dec), .use_idx(use_idx),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_ready(msg_ready)
  );

  // transfers that the next rising edge will complete
  always begin
    @(negedge clk);
    #2;
    if (rst_n && msg_valid && msg_ready && got_n < 64) begin
      got_a[got_n] = msg_addr;
      got_d[got_n] = msg_data;
      got_n++;
    end
  end

  function automatic logic [63:0] exp_a(int v);
    return {32'h0000_0100 + 32'(v), 32'hFEE0_0000 + 32'(v) * 32'd16};
  endfunction
  function automatic logic [31:0] exp_d(int v);
    return 32'hCAFE_0000 + 32'(v);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #4;
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #4;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic ctl(logic en, logic fm);
    @(negedge clk);
    ctl_we = 1'b1; ctl_enable = en; ctl_fmask = fm;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic use_op(logic up, int v);
    @(negedge clk);
    use_inc = up; use_dec = !up; use_idx = 5'(v);
    @(negedge clk);
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic irq(int v);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = 5'(v);
    #4;
    while (!irq_ready) begin
      @(negedge clk);
      #4;
    end
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic msg_chk(string tag, int idx, int v);
    chk(tag, 64'(got_d[idx]), 64'(exp_d(v)));
    chk(tag, got_a[idx], exp_a(v));
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 msg_valid", 64'(msg_valid), 0);
    chk("R1 irq_ready", 64'(irq_ready), 1);
    chk("R1 enable", 64'(cfg_enable), 0);
    chk("R1 fmask", 64'(cfg_fmask), 0);
    chk("R1 tbl_size", 64'(tbl_size), 64'(NV - 1));
    for (int v = 0; v < NV; v++) begin
      rd_chk("R1 ctrl mask", 12'(v * 16 + 12), 32'd1);
      rd_chk("R1 addr lo", 12'(v * 16), 32'd0);
    end
    rd_chk("R1 beyond table", 12'(NV * 16 + 12), 32'd0);
    rd_chk("R1 pending", 12'h800, 32'd0);

    // R2 layout, low address bits ignored
    for (int v = 0; v < NV; v++) begin
      logic [63:0] a;
      a = exp_a(v);
      reg_wr(12'(v * 16), a[31:0]);
      reg_wr(12'(v * 16 + 5), a[63:32]);
      reg_wr(12'(v * 16 + 10), exp_d(v));
    end
    for (int v = 0; v < NV; v++) begin
      logic [63:0] a;
      a = exp_a(v);
      rd_chk("R2 addr lo", 12'(v * 16 + 3), a[31:0]);
      rd_chk("R2 addr hi", 12'(v * 16 + 4), a[63:32]);
      rd_chk("R2 data", 12'(v * 16 + 8), exp_d(v));
    end
    reg_wr(12'(v_ctrl(1)), 32'hFFFF_FFFF);
    rd_chk("R2 ctrl reserved bits", 12'(v_ctrl(1)), 32'd1);
    // R3 discarded writes
    reg_wr(12'(NV * 16), 32'h1234_5678);
    rd_chk("R3 oor entry", 12'(NV * 16), 32'd0);
    reg_wr(12'h800, 32'hFFFF_FFFF);
    rd_chk("R3 pending ro", 12'h800, 32'd0);

    // declare use: v0 twice, v1..v6 once, v7 unused
    use_op(1'b1, 0);
    for (int v = 0; v < NV - 1; v++) use_op(1'b1, v);
    ctl(1'b1, 1'b0);
    wait_n(NV + 4);
    chk("R1 enable set", 64'(cfg_enable), 1);

    // R4 masked vectors latch pending; R8 unused vector dropped
    for (int v = 0; v < NV; v++) irq(v);
    irq(20);
    wait_n(3);
    rd_chk("R4 pending latch", 12'h800, 32'h7F);
    chk("R4 no message", 64'(got_n), 0);

    // R6 per-vector unmask replays
    reg_wr(12'(v_ctrl(3)), 32'd0);
    wait_n(NV + 4);
    chk("R6 count", 64'(got_n), 1);
    msg_chk("R6 msg", 0, 3);
    rd_chk("R6 pending", 12'h800, 32'h77);

    // R4 function mask blocks replay
    ctl(1'b1, 1'b1);
    reg_wr(12'(v_ctrl(0)), 32'd0);
    reg_wr(12'(v_ctrl(1)), 32'd0);
    wait_n(NV + 4);
    chk("R4 fmask holds", 64'(got_n), 1);
    chk("R4 fmask bit", 64'(cfg_fmask), 1);
    rd_chk("R4 pending kept", 12'h800, 32'h77);

    // R7 function unmask replays in order, with a stalled port (R10)
    @(negedge clk);
    msg_ready = 1'b0;
    ctl(1'b1, 1'b0);
    wait_n(6);
    chk("R10 held valid", 64'(msg_valid), 1);
    chk("R10 held data", 64'(msg_data), 64'(exp_d(0)));
    chk("R10 irq blocked", 64'(irq_ready), 0);
    @(negedge clk);
    msg_ready = 1'b1;
    wait_n(NV + 4);
    chk("R7 count", 64'(got_n), 3);
    msg_chk("R7 first", 1, 0);
    msg_chk("R7 second", 2, 1);
    rd_chk("R7 pending", 12'h800, 32'h74);

    // R5 direct delivery
    irq(3);
    wait_n(2);
    chk("R5 count", 64'(got_n), 4);
    msg_chk("R5 msg", 3, 3);
    rd_chk("R5 pending", 12'h800, 32'h74);

    // R9 use count fall clears pending; R8 drop when unused
    use_op(1'b0, 2);
    wait_n(1);
    rd_chk("R9 pending cleared", 12'h800, 32'h70);
    irq(2);
    wait_n(2);
    rd_chk("R8 unused dropped", 12'h800, 32'h70);
    chk("R8 no message", 64'(got_n), 4);
    use_op(1'b0, 0);
    irq(0);
    wait_n(2);
    chk("R9 still used", 64'(got_n), 5);
    msg_chk("R9 msg", 4, 0);

    // R4 disable masks function; R7 re-enable replays
    ctl(1'b0, 1'b0);
    irq(1);
    wait_n(2);
    rd_chk("R4 disabled latch", 12'h800, 32'h72);
    chk("R4 disabled no msg", 64'(got_n), 5);
    ctl(1'b1, 1'b0);
    wait_n(NV + 4);
    chk("R7 reenable count", 64'(got_n), 6);
    msg_chk("R7 reenable msg", 5, 1);

    // sweep: unmask the rest (R6), then direct requests on every used vector (R5)
    for (int v = 4; v < NV - 1; v++) begin
      base = got_n;
      reg_wr(12'(v_ctrl(v)), 32'd0);
      wait_n(NV + 4);
      chk("R6 sweep count", 64'(got_n), 64'(base + 1));
      msg_chk("R6 sweep msg", base, v);
    end
    rd_chk("R6 sweep pending", 12'h800, 32'h0);
    for (int v = 0; v < NV - 1; v++) begin
      if (v != 2) begin
        base = got_n;
        irq(v);
        wait_n(2);
        chk("R5 sweep count", 64'(got_n), 64'(base + 1));
        msg_chk("R5 sweep msg", base, v);
      end
    end

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 re-reset enable", 64'(cfg_enable), 0);
    rd_chk("R1 re-reset mask", 12'(v_ctrl(4)), 32'd1);
    rd_chk("R1 re-reset data", 12'(4 * 16 + 8), 32'd0);
    rd_chk("R1 re-reset pending", 12'h800, 32'd0);

    summary();
    $finish;
  end

  function automatic int v_ctrl(int v);
    return v * 16 + 12;
  endfunction
endmodule